// File: doc/BRIEF.md
# Receive Message FIFO with Watermark and Loss Flags

This block holds received message entries between a bus receive path and a host processor. A producer pushes one entry per cycle. The host finds out how many entries are waiting by polling the fill level and the get index. It reads the entry shown at the get index, then acknowledges it. Only the acknowledge frees the slot. The block keeps three sticky interrupt flags, each cleared by writing a one to it:

- a new-entry flag;
- a watermark flag, raised when the programmed fill threshold is met;
- a loss flag.

When every slot is occupied, a mode input selects one of two policies. In blocking mode the incoming entry is dropped. In overwrite mode the oldest stored entry is replaced. Either way the loss is flagged.

No timer reports entries that wait below the threshold. A host that uses the watermark must still poll the fill level to collect the remainder.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset, fill level, get index and put index are 0, full is low, and all three flags are low.
- R2: A push while not full stores the entry at the put index, advances the put index and raises the fill level by one. The stored entry appears on rd_data one cycle after the get index points at it and the write has completed.
- R3: An acknowledge while the fill level is non-zero advances the get index and lowers the fill level by one. An acknowledge while empty changes nothing.
- R4: The new-entry flag (flag bit 0) is set in every cycle in which an entry is written into the FIFO.
- R5: The watermark flag (flag bit 1) is set when a write leaves the fill level at or above wm_level. A wm_level of 0 never sets it.
- R6: In blocking mode (overwrite_mode = 0), a push while full is dropped. Fill level, indices and stored contents stay unchanged, and the loss flag (flag bit 2) is set.
- R7: In overwrite mode (overwrite_mode = 1), a push while full writes over the oldest entry. The put and get indices both advance, the fill level stays at DEPTH, and both the loss flag and the new-entry flag are set.
- R8: Writing a one to bit i of flag_clr clears flag i. If a set event for flag i occurs in the same cycle, the set takes priority.
- R9: A push and an acknowledge in the same cycle while full are both accepted. The fill level stays at DEPTH and no loss is flagged.
- R10: full is high exactly when the fill level equals DEPTH.
- R11: With no push, no flag becomes set on its own, however long entries wait below the watermark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Producer offers an entry this cycle |
| push_data | input | DATA_W | Entry to store |
| host_ack | input | 1 | Host releases the entry at the get index |
| overwrite_mode | input | 1 | 0 = drop when full, 1 = overwrite oldest |
| wm_level | input | CNT_W | Watermark threshold (0 disables) |
| flag_clr | input | 3 | Write-one-to-clear for {lost, wm, new} |
| rd_data | output | DATA_W | Entry at the get index (registered) |
| fill_level | output | CNT_W | Number of stored entries |
| get_idx | output | IDX_W | Slot of the oldest entry |
| put_idx | output | IDX_W | Slot the next entry is written to |
| full | output | 1 | All slots occupied |
| flag_new | output | 1 | Sticky new-entry flag |
| flag_wm | output | 1 | Sticky watermark flag |
| flag_lost | output | 1 | Sticky entry-lost flag |

## Verification
A slip in a pointer or in the fill count shows at the ports within one cycle. The put index then stops matching the get index plus the fill level, modulo DEPTH, and full disagrees with the fill level. A wrong slot choice in overwrite or blocking mode shows later, on rd_data: the entries the host drains come out in the wrong order or with the wrong values. The bench therefore drains the FIFO completely after each full-policy event. A flag driven by the wrong condition shows one cycle after the offending push, acknowledge or clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int FLG_W    = 3;
  localparam int FLG_NEW  = 0;
  localparam int FLG_WM   = 1;
  localparam int FLG_LOST = 2;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             ack,
  input  logic             ovw,
  output logic             wr_en,
  output logic             lost_evt,
  output logic [CNT_W-1:0] fill_nxt,
  output logic [IDX_W-1:0] put_q,
  output logic [IDX_W-1:0] get_q,
  output logic [CNT_W-1:0] fill_q,
  output logic             full_q
);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic pop, room, store_acc, store_ovw, adv_get;

  always_comb begin
    pop       = ack && (fill_q != '0);
    room      = !full_q || pop;
    store_acc = push && room;
    store_ovw = push && !room && ovw;
    wr_en     = store_acc || store_ovw;
    lost_evt  = push && !room;
    adv_get   = pop || store_ovw;
    fill_nxt  = fill_q + CNT_W'(store_acc) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      put_q  <= '0;
      get_q  <= '0;
      fill_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_en)   put_q <= (put_q == LAST) ? '0 : put_q + 1'b1;
      if (adv_get) get_q <= (get_q == LAST) ? '0 : get_q + 1'b1;
      fill_q <= fill_nxt;
      full_q <= (fill_nxt == FULLC);
    end
  end

  // R10
  full_matches_fill_chk: assert property (@(posedge clk) disable iff (rst)
    full_q == (fill_q == FULLC));
  // R2
  ring_consistent_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(put_q) == (32'(get_q) + 32'(fill_q)) % DEPTH));
  // R3
  empty_ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !push && fill_q == '0) |=> ($stable(get_q) && fill_q == '0));
  // R7
  overwrite_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !ack && full_q && ovw) |=> (fill_q == FULLC && get_q != $past(get_q)));
  // R6
  block_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !ack && full_q && !ovw) |=> ($stable(put_q) && $stable(get_q)));
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int CNT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stored,
  input  logic                     lost_evt,
  input  logic [CNT_W-1:0]         fill_nxt,
  input  logic [CNT_W-1:0]         wm_level,
  input  logic [rxf_pkg::FLG_W-1:0] clr,
  output logic [rxf_pkg::FLG_W-1:0] flags_q
);
  import rxf_pkg::*;

  logic [FLG_W-1:0] set_v;

  always_comb begin
    set_v           = '0;
    set_v[FLG_NEW]  = stored;
    set_v[FLG_WM]   = stored && (wm_level != '0) && (fill_nxt >= wm_level);
    set_v[FLG_LOST] = lost_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= set_v | (flags_q & ~clr);
  end

  // R4
  new_needs_store_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[FLG_NEW]) |-> $past(stored));
  // R6
  lost_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[FLG_LOST]) |-> $past(lost_evt));
  // R5
  wm_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (wm_level == '0 && !flags_q[FLG_WM]) |=> !flags_q[FLG_WM]);
  // R8
  clear_works_chk: assert property (@(posedge clk) disable iff (rst)
    (clr[FLG_LOST] && !lost_evt) |=> !flags_q[FLG_LOST]);
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              host_ack,
  input  logic              overwrite_mode,
  input  logic [CNT_W-1:0]  wm_level,
  input  logic [2:0]        flag_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fill_level,
  output logic [IDX_W-1:0]  get_idx,
  output logic [IDX_W-1:0]  put_idx,
  output logic              full,
  output logic              flag_new,
  output logic              flag_wm,
  output logic              flag_lost
);
  import rxf_pkg::*;

  logic             wr_en, lost_evt;
  logic [CNT_W-1:0] fill_nxt;
  logic [FLG_W-1:0] flags;

  rxf_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .push(push_valid), .ack(host_ack), .ovw(overwrite_mode),
    .wr_en(wr_en), .lost_evt(lost_evt), .fill_nxt(fill_nxt),
    .put_q(put_idx), .get_q(get_idx), .fill_q(fill_level), .full_q(full)
  );

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(put_idx), .wr_data(push_data),
    .rd_idx(get_idx), .rd_data(rd_data)
  );

  rxf_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst(rst), .stored(wr_en), .lost_evt(lost_evt),
    .fill_nxt(fill_nxt), .wm_level(wm_level), .clr(flag_clr), .flags_q(flags)
  );

  assign flag_new  = flags[FLG_NEW];
  assign flag_wm   = flags[FLG_WM];
  assign flag_lost = flags[FLG_LOST];
endmodule

// File: tb/rx_msg_fifo_tb.sv
module rx_msg_fifo_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;
  localparam int IDX_W  = 2;
  localparam int CNT_W  = 3;

  logic clk = 0, rst = 1, push_valid = 0, host_ack = 0, overwrite_mode = 0;
  logic [DATA_W-1:0] push_data = '0;
  logic [CNT_W-1:0]  wm_level = '0;
  logic [2:0]        flag_clr = '0;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  fill_level;
  logic [IDX_W-1:0]  get_idx, put_idx;
  logic full, flag_new, flag_wm, flag_lost;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_msg_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .host_ack(host_ack), .overwrite_mode(overwrite_mode), .wm_level(wm_level),
    .flag_clr(flag_clr), .rd_data(rd_data), .fill_level(fill_level),
    .get_idx(get_idx), .put_idx(put_idx), .full(full), .flag_new(flag_new),
    .flag_wm(flag_wm), .flag_lost(flag_lost)
  );

  // {push, ack, ovw, exp_fill[2:0], exp_full}
  localparam logic [6:0] VEC [19] = '{
    {3'b100, 3'd1, 1'b0}, {3'b100, 3'd2, 1'b0}, {3'b110, 3'd2, 1'b0},
    {3'b010, 3'd1, 1'b0}, {3'b010, 3'd0, 1'b0}, {3'b010, 3'd0, 1'b0},
    {3'b100, 3'd1, 1'b0}, {3'b100, 3'd2, 1'b0}, {3'b100, 3'd3, 1'b0},
    {3'b100, 3'd4, 1'b1}, {3'b100, 3'd4, 1'b1}, {3'b110, 3'd4, 1'b1},
    {3'b010, 3'd3, 1'b0}, {3'b101, 3'd4, 1'b1}, {3'b101, 3'd4, 1'b1},
    {3'b010, 3'd3, 1'b0}, {3'b010, 3'd2, 1'b0}, {3'b010, 3'd1, 1'b0},
    {3'b010, 3'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit p, input int d, input bit a, input logic [2:0] c);
    push_valid = p; push_data = DATA_W'(d); host_ack = a; flag_clr = c;
    @(posedge clk); #1;
    push_valid = 0; host_ack = 0; flag_clr = '0;
  endtask

  task automatic do_reset();
    rst = 1; overwrite_mode = 0; wm_level = '0;
    repeat (2) @(posedge clk); #1; rst = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000 && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(fill_level == 0 && get_idx == 0 && put_idx == 0, "R1 indices", fill_level, 0);
    chk(!full && !flag_new && !flag_wm && !flag_lost, "R1 flags",
        {full, flag_new, flag_wm, flag_lost}, 0);

    // Table walk: R2 R3 R6 R9 R10
    for (int i = 0; i < 19; i++) begin
      overwrite_mode = VEC[i][4];
      cyc(VEC[i][6], i, VEC[i][5], 3'b000);
      chk(fill_level == VEC[i][3:1], $sformatf("R2 R3 R6 R9 fill vec%0d", i),
          fill_level, VEC[i][3:1]);
      chk(full == VEC[i][0], $sformatf("R10 full vec%0d", i), full, VEC[i][0]);
    end
    chk(32'(put_idx) == 32'(get_idx), "R2 ring after drain", put_idx, get_idx);

    // R2 data order and R3 ack advance
    do_reset();
    cyc(1, 16'hA1, 0, 0); cyc(1, 16'hB2, 0, 0); cyc(1, 16'hC3, 0, 0); cyc(0, 0, 0, 0);
    chk(rd_data == 16'hA1, "R2 first entry", rd_data, 16'hA1);
    chk(put_idx == 3 && get_idx == 0, "R2 put idx", put_idx, 3);
    cyc(0, 0, 1, 0); cyc(0, 0, 0, 0);
    chk(rd_data == 16'hB2 && get_idx == 1, "R3 next entry", rd_data, 16'hB2);

    // R4 new flag, R8 clear and set priority
    chk(flag_new, "R4 new set", flag_new, 1);
    cyc(0, 0, 0, 3'b001);
    chk(!flag_new, "R8 clear new", flag_new, 0);
    cyc(1, 5, 0, 3'b001);
    chk(flag_new, "R8 set beats clear", flag_new, 1);

    // R5 watermark
    do_reset(); wm_level = 2;
    cyc(1, 1, 0, 0);
    chk(!flag_wm, "R5 below wm", flag_wm, 0);
    cyc(1, 2, 0, 0);
    chk(flag_wm, "R5 reached wm", flag_wm, 1);
    do_reset(); wm_level = 0;
    for (int k = 0; k < 4; k++) cyc(1, k, 0, 0);
    chk(!flag_wm, "R5 wm disabled", flag_wm, 0);
    chk(!flag_lost, "R6 no loss before full", flag_lost, 0);

    // R6 blocking drop
    do_reset();
    for (int k = 0; k < 4; k++) cyc(1, 10 + k, 0, 0);
    cyc(1, 99, 0, 0); cyc(0, 0, 0, 0);
    chk(flag_lost, "R6 loss flag", flag_lost, 1);
    chk(fill_level == 4 && put_idx == 0 && get_idx == 0, "R6 state held", get_idx, 0);
    chk(rd_data == 10, "R6 oldest kept", rd_data, 10);
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    chk(rd_data == 13, "R6 newest kept", rd_data, 13);

    // R7 overwrite oldest
    do_reset(); overwrite_mode = 1;
    for (int k = 0; k < 4; k++) cyc(1, 20 + k, 0, 0);
    cyc(0, 0, 0, 3'b111);
    cyc(1, 30, 0, 0); cyc(0, 0, 0, 0);
    chk(flag_lost && flag_new, "R7 flags", {flag_lost, flag_new}, 3);
    chk(get_idx == 1 && put_idx == 1 && fill_level == 4, "R7 indices", get_idx, 1);
    chk(rd_data == 21, "R7 oldest dropped", rd_data, 21);
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    chk(rd_data == 30, "R7 new entry last", rd_data, 30);

    // R9 ack with push when full: no loss
    do_reset();
    for (int k = 0; k < 4; k++) cyc(1, k, 0, 0);
    cyc(1, 7, 1, 0);
    chk(!flag_lost && fill_level == 4, "R9 no loss", flag_lost, 0);

    // R11 no spontaneous flags while waiting below watermark
    do_reset(); wm_level = 3;
    cyc(1, 3, 0, 0); cyc(0, 0, 0, 3'b111);
    repeat (50) cyc(0, 0, 0, 0);
    chk(!flag_new && !flag_wm && !flag_lost, "R11 flags idle",
        {flag_new, flag_wm, flag_lost}, 0);
    chk(fill_level == 1, "R11 level polled", fill_level, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule